// File: doc/BRIEF.md
# PPU Rendering and Scanline Detector

This block sits on the picture-side cartridge bus and works out the frame timing from what it can see there: the 14-bit picture address, the active-low picture read strobe and the CPU M2 clock. All three arrive asynchronously. They are brought into a fast local clock domain through synchronizer chains, and every decision is made on the synchronized copies.

Rendering counts as active while the read strobe keeps changing level. The strobe must change at least once within every window of three M2 rising edges. A read cycle begins on the falling edge of the synchronized strobe, and the address is captured at that edge. When three consecutive read cycles carry the same 14-bit address, the block emits a one-clock scanline pulse. It then counts lines until rendering stops. Separately, each time address bit 13 rises, which marks the start of a nametable fetch, the block latches address bit 9. That bit says whether the current tile row lies in the upper half of the screen (nametable range 0x2000 to 0x21FF) or the lower half (0x2200 to 0x23FF). The half flag is only meaningful when vertical scroll is zero.

An enable input lets the surrounding logic silence the scanline and half-screen outputs. The activity flag keeps tracking while the block is disabled.

Top module: `ppuTimingSniffer`

## Requirements
- R1: Out of reset, renderActive, scanlinePulse, scanlineCount and lowerHalf are all 0.
- R2: A change of level on the synchronized read strobe sets renderActive on the next clock. It stays set as long as each new change arrives before the third M2 rising edge that follows the previous change.
- R3: Three synchronized M2 rising edges with no read-strobe change between them clear renderActive.
- R4: A read cycle is counted on the high-to-low transition of the synchronized read strobe, using the address present at that transition. Address changes while the strobe is held low do not matter.
- R5: When a read cycle's address equals the address of each of the two read cycles before it, scanlinePulse is high for exactly one clock.
- R6: Further reads of that same address raise no further pulse. A new pulse needs a read with a different address followed by three identical reads.
- R7: scanlineCount goes up by one, modulo 2^COUNT_W, in the same clock as each scanlinePulse, and it changes at no other time except to clear.
- R8: scanlineCount is 0 in every clock that follows a clock in which renderActive was 0.
- R9: On each rising edge of synchronized address bit 13, lowerHalf takes synchronized address bit 9 (0 = upper half, 1 = lower half). It holds its value otherwise.
- R10: While enable is 0, the following clocks have scanlinePulse 0, scanlineCount 0 and lowerHalf 0. renderActive still follows R2 and R3.
- R11: Each asynchronous input passes through a two-flop synchronizer, so the first output effect of an input change appears three clocks after the edge that first samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast local clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Enables the scanline and half-screen outputs |
| m2Async | input | 1 | CPU M2 clock, asynchronous |
| rdNAsync | input | 1 | Picture read strobe, active low, asynchronous |
| addrAsync | input | 14 | Picture address bus, asynchronous |
| renderActive | output | 1 | Rendering detected |
| scanlinePulse | output | 1 | One-clock pulse at each scanline boundary |
| scanlineCount | output | COUNT_W | Lines seen since rendering started |
| lowerHalf | output | 1 | Latched half-screen indication |

## Verification
The bench goes after several corner cases:
- A run of six identical reads. A detector that restarts its run after firing would pulse twice here.
- Reads where the address changes while the strobe is held low. A design that samples the address anywhere but the falling edge would miss the line.
- More than 256 pulses in a row. A counter without proper wrap would fail here.
- Attribute fetches whose address has bit 9 set but no bit-13 rise. A latch that does not gate on that edge would flip the half flag to the lower half too early.
- An idle gap longer than three M2 periods. A design that never times out would keep renderActive high and keep the stale line count.

// File: rtl/ppuSniffPkg.sv
package ppuSniffPkg;

  // Events the datapath extracts from the synchronized bus
  typedef struct packed {
    logic rdFall;
    logic rdToggle;
    logic m2Rise;
    logic addrMatch;
  } dpEvents_t;

  // Strobes the control hands back to the datapath
  typedef struct packed {
    logic clrCount;
    logic incCount;
  } ctlStrobes_t;

endpackage

// File: rtl/ppuSniffDatapath.sv
module ppuSniffDatapath
  import ppuSniffPkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int COUNT_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HALF_BIT    = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               m2Async,
  input  logic               rdNAsync,
  input  logic [ADDR_W-1:0]  addrAsync,
  input  ctlStrobes_t        ctl,
  output dpEvents_t          ev,
  output logic [COUNT_W-1:0] scanCount,
  output logic               lowerHalf
);

  localparam int LAST   = SYNC_STAGES - 1;
  localparam int NT_BIT = ADDR_W - 1;

  logic [SYNC_STAGES-1:0] m2Sync;
  logic [SYNC_STAGES-1:0] rdSync;
  logic [ADDR_W-1:0]      addrSync [SYNC_STAGES];
  logic                   m2Prev, rdPrev, ntPrev;
  logic [ADDR_W-1:0]      lastAddr;
  logic [ADDR_W-1:0]      addrNow;
  logic                   m2Now, rdNow, ntRise;

  // Synchronizer chains
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m2Sync <= '0;
      rdSync <= '1;
      for (int i = 0; i < SYNC_STAGES; i++) addrSync[i] <= '0;
    end else begin
      m2Sync      <= {m2Sync[SYNC_STAGES-2:0], m2Async};
      rdSync      <= {rdSync[SYNC_STAGES-2:0], rdNAsync};
      addrSync[0] <= addrAsync;
      for (int i = 1; i < SYNC_STAGES; i++) addrSync[i] <= addrSync[i-1];
    end
  end

  assign m2Now   = m2Sync[LAST];
  assign rdNow   = rdSync[LAST];
  assign addrNow = addrSync[LAST];

  // Previous-sample registers for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m2Prev <= 1'b0;
      rdPrev <= 1'b1;
      ntPrev <= 1'b0;
    end else begin
      m2Prev <= m2Now;
      rdPrev <= rdNow;
      ntPrev <= addrNow[NT_BIT];
    end
  end

  assign ntRise       = !ntPrev && addrNow[NT_BIT];
  assign ev.rdFall    = rdPrev && !rdNow;
  assign ev.rdToggle  = rdPrev ^ rdNow;
  assign ev.m2Rise    = !m2Prev && m2Now;
  assign ev.addrMatch = (addrNow == lastAddr);

  // Address of the most recent read cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          lastAddr <= '0;
    else if (ev.rdFall) lastAddr <= addrNow;
  end

  // Line counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             scanCount <= '0;
    else if (ctl.clrCount) scanCount <= '0;
    else if (ctl.incCount) scanCount <= scanCount + 1'b1;
  end

  // Half-screen latch on nametable fetch start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       lowerHalf <= 1'b0;
    else if (!enable) lowerHalf <= 1'b0;
    else if (ntRise)  lowerHalf <= addrNow[HALF_BIT];
  end

endmodule

// File: rtl/ppuSniffControl.sv
module ppuSniffControl
  import ppuSniffPkg::*;
#(
  parameter int IDLE_LIMIT = 3,
  parameter int RUN_LEN    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  dpEvents_t   ev,
  output ctlStrobes_t ctl,
  output logic        renderActive,
  output logic        scanlinePulse
);

  localparam int IDLE_W = $clog2(IDLE_LIMIT + 1);
  localparam int RUN_W  = $clog2(RUN_LEN + 1);

  logic [IDLE_W-1:0] idleCnt;
  logic [RUN_W-1:0]  runLen;
  logic              sameAsLast;
  logic              lineHit;

  // M2 edges since the last strobe change, saturating at the limit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            idleCnt <= IDLE_W'(IDLE_LIMIT);
    else if (ev.rdToggle)                                 idleCnt <= '0;
    else if (ev.m2Rise && idleCnt < IDLE_W'(IDLE_LIMIT))  idleCnt <= idleCnt + 1'b1;
  end

  assign renderActive = (idleCnt < IDLE_W'(IDLE_LIMIT));

  // Length of the current run of identical read addresses
  assign sameAsLast = (runLen != '0) && ev.addrMatch;
  assign lineHit    = ev.rdFall && sameAsLast && (runLen == RUN_W'(RUN_LEN - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (ev.rdFall) begin
      if (!sameAsLast)                      runLen <= RUN_W'(1);
      else if (runLen < RUN_W'(RUN_LEN))    runLen <= runLen + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) scanlinePulse <= 1'b0;
    else       scanlinePulse <= lineHit && enable;
  end

  assign ctl.clrCount = !enable || !renderActive;
  assign ctl.incCount = lineHit && enable;

endmodule

// File: rtl/ppuTimingSniffer.sv
module ppuTimingSniffer
  import ppuSniffPkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int COUNT_W     = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HALF_BIT    = 9,
  parameter int IDLE_LIMIT  = 3,
  parameter int RUN_LEN     = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               m2Async,
  input  logic               rdNAsync,
  input  logic [ADDR_W-1:0]  addrAsync,
  output logic               renderActive,
  output logic               scanlinePulse,
  output logic [COUNT_W-1:0] scanlineCount,
  output logic               lowerHalf
);

  dpEvents_t   ev;
  ctlStrobes_t ctl;

  ppuSniffDatapath #(
    .ADDR_W(ADDR_W), .COUNT_W(COUNT_W),
    .SYNC_STAGES(SYNC_STAGES), .HALF_BIT(HALF_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .enable(enable),
    .m2Async(m2Async), .rdNAsync(rdNAsync), .addrAsync(addrAsync),
    .ctl(ctl), .ev(ev), .scanCount(scanlineCount), .lowerHalf(lowerHalf)
  );

  ppuSniffControl #(
    .IDLE_LIMIT(IDLE_LIMIT), .RUN_LEN(RUN_LEN)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .ev(ev), .ctl(ctl),
    .renderActive(renderActive), .scanlinePulse(scanlinePulse)
  );

endmodule

// File: rtl/ppuSniffChecker.sv
module ppuSniffChecker #(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               enable,
  input logic               renderActive,
  input logic               scanlinePulse,
  input logic [COUNT_W-1:0] scanlineCount,
  input logic               lowerHalf
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    scanlinePulse |=> !scanlinePulse) else $error("pulse longer than one clock"); // R5

  AST_COUNT_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    (scanlineCount != $past(scanlineCount)) |-> (scanlineCount == '0 || scanlinePulse))
    else $error("count moved without a pulse"); // R7

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !renderActive |=> (scanlineCount == '0)) else $error("count kept while idle"); // R8

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!scanlinePulse && scanlineCount == '0 && !lowerHalf))
    else $error("outputs live while disabled"); // R10

endmodule

bind ppuTimingSniffer ppuSniffChecker #(.COUNT_W(COUNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .renderActive(renderActive),
  .scanlinePulse(scanlinePulse), .scanlineCount(scanlineCount), .lowerHalf(lowerHalf)
);

// File: tb/ppuTimingSniffer_tb.sv
module ppuTimingSniffer_tb;

  localparam int COUNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic en = 1'b1;
  logic m2 = 1'b0;
  logic rdN = 1'b1;
  logic [13:0] addr = '0;
  logic m2Run = 1'b0;
  logic renderActive, scanlinePulse, lowerHalf;
  logic [COUNT_W-1:0] scanlineCount;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ppuTimingSniffer u_dut (
    .clk(clk), .rstN(rstN), .enable(en), .m2Async(m2), .rdNAsync(rdN),
    .addrAsync(addr), .renderActive(renderActive), .scanlinePulse(scanlinePulse),
    .scanlineCount(scanlineCount), .lowerHalf(lowerHalf)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct { logic m2; logic rd; logic [13:0] a; logic en; } samp_t;
  samp_t hist[$];
  int  sinceToggle;
  int  runCount;
  logic [13:0] prevReadAddr;
  logic mPulse, mHalf;
  int  mCount;

  function automatic samp_t idleSample();
    samp_t s;
    s.m2 = 1'b0; s.rd = 1'b1; s.a = '0; s.en = 1'b1;
    return s;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist = {idleSample(), idleSample(), idleSample(), idleSample()};
      sinceToggle = 3; runCount = 0; prevReadAddr = '0;
      mPulse = 0; mHalf = 0; mCount = 0;
    end else begin
      samp_t s, cur, old;
      bit active, fall, hit;
      s.m2 = m2; s.rd = rdN; s.a = addr; s.en = en;
      hist.push_front(s);
      void'(hist.pop_back());
      cur = hist[2]; old = hist[3];          // two-flop delay, R11
      active = (sinceToggle < 3);
      fall = old.rd && !cur.rd;
      hit = fall && runCount == 2 && cur.a == prevReadAddr;
      if (fall) begin
        if (runCount > 0 && cur.a == prevReadAddr) runCount = (runCount < 3) ? runCount + 1 : 3;
        else runCount = 1;
        prevReadAddr = cur.a;
      end
      if (old.rd != cur.rd) sinceToggle = 0;
      else if (!old.m2 && cur.m2 && sinceToggle < 3) sinceToggle++;
      mPulse = hit && s.en;
      if (!s.en || !active) mCount = 0;
      else if (hit) mCount = (mCount + 1) % (1 << COUNT_W);
      if (!s.en) mHalf = 0;
      else if (!old.a[13] && cur.a[13]) mHalf = cur.a[9];
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2/R3 renderActive", int'(renderActive), int'(sinceToggle < 3));
      check("R5/R6 scanlinePulse", int'(scanlinePulse), int'(mPulse));
      check("R7/R8 scanlineCount", int'(scanlineCount), mCount);
      check("R9 lowerHalf", int'(lowerHalf), int'(mHalf));
      if (scanlinePulse) pulses++;
    end
  end

  // M2 generator: period of six local clocks
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      if (m2Run) begin
        ph++;
        if (ph == 3) begin m2 = ~m2; ph = 0; end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL R1 watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // read cycle: address set, strobe low, address may move late, strobe high
  task automatic doRead(input logic [13:0] a, input logic [13:0] aLate);
    @(negedge clk) addr = a;
    @(negedge clk) rdN = 1'b0;
    @(negedge clk) addr = aLate;
    @(negedge clk) rdN = 1'b1;
  endtask

  task automatic rd(input logic [13:0] a);
    doRead(a, a);
  endtask

  task automatic lineFetch(input int row);
    logic [13:0] nt;
    for (int g = 0; g < 4; g++) begin
      nt = 14'h2000 | 14'(row << 5) | 14'(g);
      rd(nt);
      rd(14'h23C0 | 14'(g));
      rd(14'(g << 4));
      rd(14'(g << 4) | 14'h0008);
    end
    nt = 14'h2000 | 14'(row << 5) | 14'h1F;
    rd(nt); rd(nt); rd(nt);
    rd(14'h0008);
  endtask

  initial begin
    int base, c0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 renderActive", int'(renderActive), 0);
    check("R1 scanlinePulse", int'(scanlinePulse), 0);
    check("R1 scanlineCount", int'(scanlineCount), 0);
    check("R1 lowerHalf", int'(lowerHalf), 0);
    m2Run = 1'b1;

    rd(14'h0010);
    repeat (2) @(negedge clk);
    check("R2 active after strobe change", int'(renderActive), 1);

    lineFetch(1);
    repeat (4) @(negedge clk);
    check("R5 one pulse per line", pulses, 1);
    check("R7 count after one line", int'(scanlineCount), 1);
    check("R9 upper half", int'(lowerHalf), 0);
    lineFetch(2);
    lineFetch(20);
    repeat (4) @(negedge clk);
    check("R7 count after three lines", int'(scanlineCount), 3);
    check("R9 lower half after row 20", int'(lowerHalf), 1);

    base = pulses;
    for (int i = 0; i < 6; i++) rd(14'h1234);
    repeat (4) @(negedge clk);
    check("R6 no retrigger in long run", pulses - base, 1);
    rd(14'h0555);
    for (int i = 0; i < 3; i++) rd(14'h1234);
    repeat (4) @(negedge clk);
    check("R6 rearm after different address", pulses - base, 2);

    base = pulses;
    for (int i = 0; i < 3; i++) doRead(14'h0AAA, 14'h0BBB);
    repeat (4) @(negedge clk);
    check("R4 address taken at strobe fall", pulses - base, 1);

    c0 = int'(scanlineCount);
    for (int i = 0; i < 260; i++) begin
      logic [13:0] x;
      x = (i % 2 == 0) ? 14'h0100 : 14'h0200;
      rd(x); rd(x); rd(x);
    end
    repeat (4) @(negedge clk);
    check("R7 counter wraps", int'(scanlineCount), (c0 + 260) % (1 << COUNT_W));

    @(negedge clk) en = 1'b0;
    base = pulses;
    rd(14'h0008);
    for (int i = 0; i < 3; i++) rd(14'h2280);
    repeat (4) @(negedge clk);
    check("R10 no pulse when disabled", pulses - base, 0);
    check("R10 count held at zero", int'(scanlineCount), 0);
    check("R10 half flag cleared", int'(lowerHalf), 0);
    check("R10 activity still tracked", int'(renderActive), 1);
    @(negedge clk) en = 1'b1;

    repeat (40) @(negedge clk);
    check("R3 idle clears activity", int'(renderActive), 0);
    check("R8 idle clears count", int'(scanlineCount), 0);

    lineFetch(3);
    repeat (4) @(negedge clk);
    check("R7 count restarts after idle", int'(scanlineCount), 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule